// File: doc/BRIEF.md
# Double-Buffered PWM Update Controller

This block is one left-aligned PWM channel. It drives a complementary pair of outputs with separate rising-edge dead-times and pulses a marker on the last count of every period. Software never writes the period, duty or dead-time values that the counter uses. It writes shadow copies instead. The block moves each shadow into its active copy only at a period boundary, so a waveform is never torn partway through a period.

The channel can be free-running or grouped. A free-running channel takes all shadow values at the next period end. A grouped channel has an update mode input. In mode 0, every value waits for a software unlock pulse and then for the period end. In the split modes (1, 2 and 3), the period and dead-times still wait for the unlock pulse. The duty value waits for a free-running update-period counter to reach a programmable reload value at a period end.

Typical use is as a leaf in a motor or power-stage controller. Firmware writes new values at any time and sets the unlock pulse when a consistent set is ready.

Top module: `pwm_update_ctrl`

## Requirements
- R1: With `sync_ch` low, period, duty and both dead-times are copied from shadow to active at every period end.
- R2: With `sync_ch` high and `upd_mode` = 0, no value is copied until `unlock_set` has been pulsed. All values are then copied together at the next period end.
- R3: With `sync_ch` high and `upd_mode` nonzero, period and dead-times are copied only at a period end while the unlock flag is set.
- R4: With `sync_ch` high and `upd_mode` nonzero, duty is copied at a period end where the update-period counter equals `upr_reload`, whatever the state of the unlock flag. Modes 1, 2 and 3 behave alike.
- R5: A shadow written more than once between copies applies only its last value. `wr_sel` selects the value: 0 is period, 1 is duty, 2 is the `pwm_hi` dead-time and 3 is the `pwm_lo` dead-time. Dead-times take `wr_data[7:0]`.
- R6: Active values change only on the clock edge that ends a period, so a new value first shapes the following period.
- R7: The unlock flag clears on the edge of a grouped transfer that it gated. An `unlock_set` on that same edge leaves it set.
- R8: The update-period counter steps by one at each period end and returns to 0 at the period end where it equals `upr_reload`.
- R9: The counter runs from 0 to period-1, and `period_end` is high on its last count. An active period of 0 or 1 gives one-cycle periods.
- R10: The raw high phase lasts while count < duty, and the raw low phase covers the rest of the period. `pwm_hi` and `pwm_lo` are never high together.
- R11: Each output rises its own dead-time count of cycles after its raw phase starts, and falls with it. A dead-time at least as long as the phase keeps that output low for the whole phase.
- R12: After reset all shadow and active values are 0. While `chan_en` is low, `pwm_hi`, `pwm_lo` and `period_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel run enable |
| sync_ch | input | 1 | 1 selects grouped update gating |
| upd_mode | input | 2 | Grouped update mode (0 = all locked, nonzero = split) |
| upr_reload | input | 4 | Reload value for the update-period counter |
| unlock_set | input | 1 | One-cycle pulse that sets the unlock flag |
| wr_en | input | 1 | Shadow write strobe |
| wr_sel | input | 2 | Shadow select |
| wr_data | input | 16 | Shadow write data |
| pwm_hi | output | 1 | High-side output with dead-time |
| pwm_lo | output | 1 | Low-side output with dead-time |
| period_end | output | 1 | High on the last count of each period |

## Verification
A scoreboard measures the length, high time and low time of every period and compares them with a model of the active values. A wrong gate therefore appears as a period that carries a value too early or too late. The bench holds a grouped channel locked for several periods after writes, to catch a design that copies without the unlock pulse. After one unlocked transfer it tries again without unlocking, to catch a flag that never self-clears. In split mode it waits out the update-period counter, so that a design that moves the duty with the period, or at the wrong count, shows a misplaced duty change. It also writes duty twice back to back, places a write mid-period, and uses dead-times longer than the phase, to expose a first-write-wins shadow, a mid-period update or a wrapped dead-time compare.

// File: rtl/pwm_upd_pkg.sv
// Shared widths and types for the double-buffered PWM channel.
package pwm_upd_pkg;
    localparam int CNT_W = 16;   // period / duty / counter width
    localparam int DT_W  = 8;    // dead-time width
    localparam int UPR_W = 4;    // update-period counter width

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_DUTY   = 2'd1,
        SEL_DT_HI  = 2'd2,
        SEL_DT_LO  = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] prd;
        logic [CNT_W-1:0] dty;
        logic [DT_W-1:0]  dth;
        logic [DT_W-1:0]  dtl;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_shadow_regs.sv
// Shadow register bank. Holds the values software last wrote.
// Assumes one write per cycle; dead-times take the low DT_W data bits.
module pwm_shadow_regs
    import pwm_upd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    output pwm_cfg_t          shd
);
    // Capture the selected field; a later write overwrites an earlier one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd <= '0;
        end else if (wr_en) begin
            case (wr_sel_e'(wr_sel))
                SEL_PERIOD: shd.prd <= wr_data;
                SEL_DUTY:   shd.dty <= wr_data;
                SEL_DT_HI:  shd.dth <= wr_data[DT_W-1:0];
                default:    shd.dtl <= wr_data[DT_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/pwm_update_gate.sv
// Decides, per value class, whether the shadow moves to active at this
// period end. Owns the self-clearing unlock flag and the update-period
// counter. Assumes period_end is a one-cycle-per-period strobe.
module pwm_update_gate
    import pwm_upd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_end,
    input  logic              sync_ch,
    input  logic [1:0]        upd_mode,
    input  logic [UPR_W-1:0]  upr_reload,
    input  logic              unlock_set,
    output logic              load_main,
    output logic              load_dty
);
    localparam logic [UPR_W-1:0] UPR_ONE = 1;

    logic             unlock_q;
    logic [UPR_W-1:0] upr_q;
    logic             upr_hit;
    logic             split_mode;

    assign upr_hit    = (upr_q == upr_reload);
    assign split_mode = (upd_mode != 2'd0);

    // Gate each value class by channel type, mode, unlock and counter match.
    always_comb begin
        if (!sync_ch) begin
            load_main = period_end;
            load_dty  = period_end;
        end else if (!split_mode) begin
            load_main = period_end && unlock_q;
            load_dty  = period_end && unlock_q;
        end else begin
            load_main = period_end && unlock_q;
            load_dty  = period_end && upr_hit;
        end
    end

    // Unlock flag: a set pulse wins, a gated grouped transfer clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlock_q <= 1'b0;
        else if (unlock_set)
            unlock_q <= 1'b1;
        else if (sync_ch && load_main)
            unlock_q <= 1'b0;
    end

    // Update-period counter: step per period, wrap to zero on a match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upr_q <= '0;
        else if (period_end)
            upr_q <= upr_hit ? '0 : upr_q + UPR_ONE;
    end

    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ch && !unlock_q) |-> !load_main);
    assert_unlock_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ch && load_main && !unlock_set) |=> !unlock_q);
    assert_upr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !upr_hit) |=> (upr_q == $past(upr_q) + UPR_ONE));
    assert_upr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && upr_hit) |=> (upr_q == '0));
endmodule

// File: rtl/pwm_wave_gen.sv
// Active register bank, left-aligned period counter and complementary
// outputs with per-side rising-edge dead-time. Assumes load strobes
// arrive only together with period_end.
module pwm_wave_gen
    import pwm_upd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      chan_en,
    input  pwm_cfg_t  shd,
    input  logic      load_main,
    input  logic      load_dty,
    output logic      pwm_hi,
    output logic      pwm_lo,
    output logic      period_end
);
    localparam int NLEG = 2;
    localparam logic [CNT_W-1:0] CNT_ONE = 1;
    localparam logic [DT_W-1:0]  DT_ONE  = 1;

    pwm_cfg_t         act_q;
    logic [CNT_W-1:0] cnt_q;
    logic             raw_hi;
    logic [NLEG-1:0]  leg_raw;
    logic [DT_W-1:0]  leg_dt  [NLEG];
    logic [DT_W-1:0]  leg_age [NLEG];
    logic [NLEG-1:0]  leg_out;

    assign period_end = chan_en && ((act_q.prd <= CNT_ONE) || (cnt_q == act_q.prd - CNT_ONE));
    assign raw_hi     = chan_en && (cnt_q < act_q.dty);
    assign leg_raw[0] = raw_hi;
    assign leg_raw[1] = chan_en && !raw_hi;
    assign leg_dt[0]  = act_q.dth;
    assign leg_dt[1]  = act_q.dtl;

    // Active values: copied from shadow only on gated period ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            if (load_main) begin
                act_q.prd <= shd.prd;
                act_q.dth <= shd.dth;
                act_q.dtl <= shd.dtl;
            end
            if (load_dty)
                act_q.dty <= shd.dty;
        end
    end

    // Period counter: 0 up to period-1, held at 0 while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_en || period_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_ONE;
    end

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        // Age of the current raw phase, saturating, cleared when it ends.
        always_ff @(posedge clk) begin
            if (!rst_n || !leg_raw[g])
                leg_age[g] <= '0;
            else if (leg_age[g] != '1)
                leg_age[g] <= leg_age[g] + DT_ONE;
        end
        assign leg_out[g] = leg_raw[g] && (leg_age[g] >= leg_dt[g]);
    end

    assign pwm_hi = leg_out[0];
    assign pwm_lo = leg_out[1];

    assert_active_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(act_q));
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && act_q.prd > CNT_ONE) |-> (cnt_q < act_q.prd));
    assert_complement_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_hi && pwm_lo));
    assert_idle_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> (!pwm_hi && !pwm_lo && !period_end));
    assert_dt_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwm_hi) && act_q.dth != '0) |-> $past(raw_hi));
endmodule

// File: rtl/pwm_update_ctrl.sv
// Top of the double-buffered PWM channel: shadow bank, update gate and
// waveform generator. Assumes all inputs are synchronous to clk.
module pwm_update_ctrl
    import pwm_upd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              sync_ch,
    input  logic [1:0]        upd_mode,
    input  logic [UPR_W-1:0]  upr_reload,
    input  logic              unlock_set,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_hi,
    output logic              pwm_lo,
    output logic              period_end
);
    pwm_cfg_t shd;
    logic     load_main;
    logic     load_dty;
    logic     pend;

    pwm_shadow_regs u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .shd     (shd)
    );

    pwm_update_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_end (pend),
        .sync_ch    (sync_ch),
        .upd_mode   (upd_mode),
        .upr_reload (upr_reload),
        .unlock_set (unlock_set),
        .load_main  (load_main),
        .load_dty   (load_dty)
    );

    pwm_wave_gen u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .shd        (shd),
        .load_main  (load_main),
        .load_dty   (load_dty),
        .pwm_hi     (pwm_hi),
        .pwm_lo     (pwm_lo),
        .period_end (pend)
    );

    assign period_end = pend;
endmodule

// File: tb/sim_pwm_update_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_update_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic        sync_ch = 1'b0;
    logic [1:0]  upd_mode = 2'd0;
    logic [3:0]  upr_reload = 4'd0;
    logic        unlock_set = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_hi, pwm_lo, period_end;

    always #2.5 clk = ~clk;

    pwm_update_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sync_ch(sync_ch),
        .upd_mode(upd_mode), .upr_reload(upr_reload), .unlock_set(unlock_set),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .period_end(period_end)
    );

    typedef struct { int len; int hi; int lo; string tag; } exp_t;
    exp_t  sb_q[$];
    int    checks = 0, fails = 0;
    string phase = "R12";

    // Bench model of shadow/active state, built from the requirements.
    int s_prd = 0, s_dty = 0, s_dth = 0, s_dtl = 0;
    int a_prd = 0, a_dty = 0, a_dth = 0, a_dtl = 0;
    bit m_unlock = 0;
    logic [3:0] m_upr = 4'd0;
    bit p_wr = 0, p_unl = 0;
    int p_sel = 0, p_val = 0;
    int acc_len = 0, acc_hi = 0, acc_lo = 0;
    bit both_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic exp_t mk_exp(input string tag);
        exp_t e;
        e.tag = tag;
        if (a_prd <= 1) begin
            e.len = 1; e.hi = 0; e.lo = 1;
        end else begin
            e.len = a_prd;
            e.hi  = (a_dty > a_dth) ? a_dty - a_dth : 0;
            e.lo  = (a_prd - a_dty > a_dtl) ? a_prd - a_dty - a_dtl : 0;
        end
        return e;
    endfunction

    // Driver side: the item for the very first (all-zero) period.
    task automatic push_first();
        sb_q.push_back(mk_exp("R12"));
    endtask

    // Monitor: measure each period, compare, then advance the model.
    always @(negedge clk) begin
        if (rst_n && chan_en) begin
            acc_len++;
            acc_hi += int'(pwm_hi);
            acc_lo += int'(pwm_lo);
            if (pwm_hi && pwm_lo) both_seen = 1;
            if (period_end) begin
                if (sb_q.size() > 0) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(acc_len == e.len, {"R9 ", e.tag}, "period length", acc_len, e.len);
                    chk(acc_hi == e.hi, {"R10 ", e.tag}, "high cycles", acc_hi, e.hi);
                    chk(acc_lo == e.lo, {"R11 ", e.tag}, "low cycles", acc_lo, e.lo);
                    chk(!both_seen, "R10", "both outputs high", int'(both_seen), 0);
                end
                acc_len = 0; acc_hi = 0; acc_lo = 0; both_seen = 0;
                begin
                    bit lm, ld;
                    if (!sync_ch) begin lm = 1; ld = 1; end
                    else if (upd_mode == 2'd0) begin lm = m_unlock; ld = m_unlock; end
                    else begin lm = m_unlock; ld = (m_upr == upr_reload); end
                    if (lm) begin a_prd = s_prd; a_dth = s_dth; a_dtl = s_dtl; end
                    if (ld) a_dty = s_dty;
                    if (sync_ch && lm) m_unlock = 0;
                    m_upr = (m_upr == upr_reload) ? 4'd0 : m_upr + 4'd1;
                end
                sb_q.push_back(mk_exp(phase));
            end
        end
        if (p_unl) begin m_unlock = 1; p_unl = 0; end
        if (p_wr) begin
            case (p_sel)
                0: s_prd = p_val;
                1: s_dty = p_val;
                2: s_dth = p_val & 255;
                default: s_dtl = p_val & 255;
            endcase
            p_wr = 0;
        end
    end

    task automatic drive_wr(input int sel, input int val);
        @(posedge clk); #1;
        wr_en = 1; wr_sel = 2'(sel); wr_data = 16'(val);
        p_wr = 1; p_sel = sel; p_val = val;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic pulse_unlock();
        @(posedge clk); #1;
        unlock_set = 1; p_unl = 1;
        @(posedge clk); #1;
        unlock_set = 0;
    endtask

    task automatic set_cfg(input bit s, input int m, input int rl);
        @(posedge clk); #1;
        sync_ch = s; upd_mode = 2'(m); upr_reload = 4'(rl);
    endtask

    task automatic wait_periods(input int n);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (period_end) seen++;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stimulus
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R12: reset state, outputs idle while disabled
        @(negedge clk);
        chk(!pwm_hi && !pwm_lo, "R12", "outputs after reset", int'(pwm_hi | pwm_lo), 0);
        chk(!period_end, "R12", "period_end after reset", int'(period_end), 0);
        // R5: shadows loaded while idle; duty written twice
        drive_wr(0, 10);
        drive_wr(1, 6);
        drive_wr(1, 4);
        drive_wr(2, 1);
        drive_wr(3, 2);
        repeat (3) @(negedge clk);
        chk(!pwm_hi && !pwm_lo && !period_end, "R12", "idle with shadows set",
            int'(pwm_hi | pwm_lo | period_end), 0);
        push_first();
        phase = "R1";
        @(posedge clk); #1 chan_en = 1;
        wait_periods(3);
        phase = "R5";
        drive_wr(1, 6);
        drive_wr(1, 5);
        wait_periods(3);
        phase = "R6";
        wait_periods(1);
        repeat (3) @(posedge clk);
        drive_wr(0, 12);
        wait_periods(3);
        phase = "R11";
        drive_wr(2, 6);
        wait_periods(2);
        drive_wr(3, 9);
        wait_periods(2);
        drive_wr(2, 1);
        drive_wr(3, 2);
        wait_periods(2);
        phase = "R2";
        set_cfg(1, 0, 0);
        drive_wr(0, 9);
        wait_periods(3);
        pulse_unlock();
        wait_periods(3);
        phase = "R7";
        drive_wr(0, 10);
        wait_periods(3);
        pulse_unlock();
        wait_periods(2);
        phase = "R4";
        set_cfg(1, 1, 2);
        drive_wr(0, 12);
        drive_wr(1, 7);
        wait_periods(20);
        phase = "R3";
        pulse_unlock();
        wait_periods(3);
        phase = "R8";
        set_cfg(1, 1, 0);
        drive_wr(1, 3);
        wait_periods(20);
        phase = "R4";
        set_cfg(1, 3, 0);
        drive_wr(1, 6);
        wait_periods(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule